// File: doc/BRIEF.md
# Input Edge Event Counter

This block counts transitions on an asynchronous external input. The input is brought into the clock domain by a synchronizer, and a programmable selection picks which transitions count: rising, falling, both, or none. Each selected transition moves a 24-bit count, made of a 16-bit lower part and an 8-bit prescaler extension. In up mode the count climbs from zero and wraps back to zero. In down mode it starts at a programmed start value and, once the programmed number of events has arrived, it stops by itself and clears its own enable.

Writing the enable with a 1 takes a snapshot of the direction, edge selection, start value and match value, checks them and starts a run. Every wrap in up mode and the terminal event in down mode set a sticky match flag. Software clears that flag by writing a one to the clear strobe. An interrupt output shows the flag whenever the mask allows it. Software reads the enable state to learn whether a down-mode run has finished.

Control state machine: `ST_OFF` (idle after reset or after a disable), `ST_UP` (counting upward), `ST_DOWN` (counting downward), `ST_HALT` (down run finished, enable cleared) and `ST_BAD` (enabled with an illegal setup, not counting). Transitions: any state goes to `ST_UP`, `ST_DOWN` or `ST_BAD` on an enable write of 1, chosen by direction and legality. Any state goes to `ST_OFF` on an enable write of 0. `ST_DOWN` goes to `ST_HALT` on the terminal event.

Top module: `evc_top`

## Requirements
- R1: After reset `cnt_out` is 0, `match_flag` is 0, `irq` is 0 and `run_en` is 0.
- R2: `edge_sel` chooses the counted transitions of `evt_in`: 2'b01 rising only, 2'b10 falling only, 2'b11 both, 2'b00 none. With 2'b11 one high pulse counts twice. No other input change moves the count, except an enable write.
- R3: With `dir_up`=1 an enable write of 1 sets the count to 0. Each event adds one. On the event that would make the count equal the match value, the count goes back to 0 and the match flag is set. Counting then continues.
- R4: With `dir_up`=0 an enable write of 1 sets the count to the start value (`load_val`) and each event subtracts one. On event number start minus match, the count reloads the start value, the match flag is set and `run_en` falls to 0. Later events leave the count unchanged.
- R5: While `run_en` is 0, events do not move the count. This holds after a write of 0 and after a down-mode stop. A new enable write of 1 reloads the start value (down) or zero (up) and counting resumes.
- R6: If the start value is not greater than the match value when the enable is written with 1, `run_en` reads 1 but the count stays at its initial value and the match flag never sets.
- R7: A one-cycle pulse on `flag_clr` clears `match_flag`.
- R8: `irq` is high only while `match_flag` is 1 and `irq_mask` is 1.
- R9: A transition on `evt_in` becomes visible in `cnt_out` at the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Asynchronous event input |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Value written to the enable |
| dir_up | input | 1 | 1 up-counting, 0 down-counting, sampled on enable |
| edge_sel | input | 2 | Counted transition type, sampled on enable |
| load_val | input | 24 | Start value, sampled on enable |
| match_val | input | 24 | Match value, sampled on enable |
| irq_mask | input | 1 | Interrupt mask, 1 passes the flag |
| flag_clr | input | 1 | Write-one-to-clear strobe for the match flag |
| cnt_out | output | 24 | Live count |
| match_flag | output | 1 | Sticky match status |
| irq | output | 1 | Masked interrupt |
| run_en | output | 1 | Enable state, cleared by the block on a down-mode stop |

## Verification
The bench targets these corner cases:
- The terminal down-mode event. A design that compares against the wrong value stops one event early or late, and the count then reads something other than the start value.
- Events that arrive after the stop. A design that keeps counting would move the count away from the reloaded start value.
- An up-mode wrap under both-edge selection, where a wrong comparison shows up as a count offset by one.
- Illegal setups where the start value equals or is below the match value. A faulty design raises the flag or counts.
- A down count that borrows across the boundary between the 16-bit part and the prescaler part, which catches a broken carry.
- The three-edge input latency, where a missing or extra synchronizer stage moves the first count change.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_UP   = 3'd1,
        ST_DOWN = 3'd2,
        ST_HALT = 3'd3,
        ST_BAD  = 3'd4
    } evc_state_e;

endpackage

// File: rtl/evc_edge_det.sv
module evc_edge_det
    import evc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_raw,
    input  edge_sel_e sel,
    output logic      hit
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              rise;
    logic              fall;
    logic [1:0]        sel_bits;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    always_comb begin
        sel_bits = sel;
        rise     = chain_q[STAGES-1] & ~last_q;
        fall     = ~chain_q[STAGES-1] & last_q;
        hit      = (sel_bits[0] & rise) | (sel_bits[1] & fall);
    end

endmodule

// File: rtl/evc_core.sv
module evc_core
    import evc_pkg::*;
#(
    parameter  int LOW_W = 16,
    parameter  int PRE_W = 8,
    localparam int CNT_W = LOW_W + PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             dir_up,
    input  edge_sel_e        edge_in,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             ev_hit,
    output edge_sel_e        edge_cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             match_pulse,
    output logic             run_en
);

    evc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ld_q;
    logic [CNT_W-1:0] mt_q;
    edge_sel_e        edge_q;

    logic             start;
    logic             stop;
    logic             legal_in;
    evc_state_e       start_tgt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_dec;
    logic             up_wrap;
    logic             dn_done;

    always_comb begin
        start     = en_wr & en_wdata;
        stop      = en_wr & ~en_wdata;
        legal_in  = load_val > match_val;
        start_tgt = !legal_in ? ST_BAD : (dir_up ? ST_UP : ST_DOWN);
        cnt_inc   = cnt_q + 1'b1;
        cnt_dec   = cnt_q - 1'b1;
        up_wrap   = ev_hit & (cnt_inc == mt_q);
        dn_done   = ev_hit & (cnt_dec == mt_q);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = ST_OFF;
            ST_UP:   state_d = ST_UP;
            ST_DOWN: if (dn_done) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
            ST_BAD:  state_d = ST_BAD;
            default: state_d = ST_OFF;
        endcase
        if (start)     state_d = start_tgt;
        else if (stop) state_d = ST_OFF;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Setup snapshot, taken on an enable write of 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q   <= '0;
            mt_q   <= '0;
            edge_q <= EDGE_NONE;
        end else if (start) begin
            ld_q   <= load_val;
            mt_q   <= match_val;
            edge_q <= edge_in;
        end
    end

    // Count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= dir_up ? '0 : load_val;
        end else if (!stop) begin
            unique case (state_q)
                ST_UP:   if (ev_hit) cnt_q <= up_wrap ? '0 : cnt_inc;
                ST_DOWN: if (ev_hit) cnt_q <= dn_done ? ld_q : cnt_dec;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cnt         = cnt_q;
        edge_cfg    = edge_q;
        run_en      = (state_q == ST_UP) || (state_q == ST_DOWN) || (state_q == ST_BAD);
        match_pulse = ~en_wr & (((state_q == ST_UP) & up_wrap) |
                                ((state_q == ST_DOWN) & dn_done));
    end

endmodule

// File: rtl/evc_flag.sv
module evc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_w1c,
    input  logic irq_mask,
    output logic flag,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (set_pulse) flag_q <= 1'b1;
        else if (clr_w1c)   flag_q <= 1'b0;
    end

    always_comb begin
        flag = flag_q;
        irq  = flag_q & irq_mask;
    end

endmodule

// File: rtl/evc_top.sv
module evc_top
    import evc_pkg::*;
#(
    parameter  int LOW_W       = 16,
    parameter  int PRE_W       = 8,
    parameter  int SYNC_STAGES = 2,
    localparam int CNT_W       = LOW_W + PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             dir_up,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             irq_mask,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_out,
    output logic             match_flag,
    output logic             irq,
    output logic             run_en
);

    edge_sel_e edge_cfg;
    logic      ev_hit;
    logic      set_pulse;

    evc_edge_det #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (evt_in),
        .sel     (edge_cfg),
        .hit     (ev_hit)
    );

    evc_core #(
        .LOW_W (LOW_W),
        .PRE_W (PRE_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_wr       (en_wr),
        .en_wdata    (en_wdata),
        .dir_up      (dir_up),
        .edge_in     (edge_sel_e'(edge_sel)),
        .load_val    (load_val),
        .match_val   (match_val),
        .ev_hit      (ev_hit),
        .edge_cfg    (edge_cfg),
        .cnt         (cnt_out),
        .match_pulse (set_pulse),
        .run_en      (run_en)
    );

    evc_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (set_pulse),
        .clr_w1c   (flag_clr),
        .irq_mask  (irq_mask),
        .flag      (match_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/evc_chk.sv
module evc_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_wr,
    input logic             flag_clr,
    input logic             irq_mask,
    input logic             ev_hit,
    input logic             set_pulse,
    input logic [CNT_W-1:0] cnt_out,
    input logic             match_flag,
    input logic             irq,
    input logic             run_en
);

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ev_hit) && !$past(en_wr)) |-> $stable(cnt_out));

    // R4
    halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run_en) && !$past(en_wr)) |-> match_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_clr) && !$past(set_pulse)) |-> !match_flag);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && irq_mask));

    // R3
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> $past(set_pulse));

endmodule

bind evc_top evc_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .flag_clr   (flag_clr),
    .irq_mask   (irq_mask),
    .ev_hit     (ev_hit),
    .set_pulse  (set_pulse),
    .cnt_out    (cnt_out),
    .match_flag (match_flag),
    .irq        (irq),
    .run_en     (run_en)
);

// File: tb/sim_evc_top.sv
`timescale 1ns/1ps
module sim_evc_top;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt_in = 1'b0;
    logic         en_wr = 1'b0;
    logic         en_wdata = 1'b0;
    logic         dir_up = 1'b0;
    logic [1:0]   edge_sel = 2'b00;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] match_val = '0;
    logic         irq_mask = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] cnt_out;
    logic         match_flag;
    logic         irq;
    logic         run_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evc_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_in     (evt_in),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .dir_up     (dir_up),
        .edge_sel   (edge_sel),
        .load_val   (load_val),
        .match_val  (match_val),
        .irq_mask   (irq_mask),
        .flag_clr   (flag_clr),
        .cnt_out    (cnt_out),
        .match_flag (match_flag),
        .irq        (irq),
        .run_en     (run_en)
    );

    typedef struct packed {
        logic         up;
        logic [1:0]   edg;
        logic [W-1:0] ld;
        logic [W-1:0] mt;
        logic [7:0]   pulses;
        logic [W-1:0] ecnt;
        logic         eflag;
        logic         een;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 2'b01, 24'd10,      24'd5,       8'd3, 24'd3,       1'b0, 1'b1}, // R3 below match
        '{1'b1, 2'b01, 24'd10,      24'd5,       8'd5, 24'd0,       1'b1, 1'b1}, // R3 wrap
        '{1'b1, 2'b11, 24'd10,      24'd5,       8'd3, 24'd1,       1'b1, 1'b1}, // R2 both edges, R3
        '{1'b0, 2'b01, 24'd8,       24'd3,       8'd2, 24'd6,       1'b0, 1'b1}, // R4 partial
        '{1'b0, 2'b10, 24'd8,       24'd3,       8'd5, 24'd8,       1'b1, 1'b0}, // R2 falling, R4 stop
        '{1'b0, 2'b01, 24'd8,       24'd3,       8'd7, 24'd8,       1'b1, 1'b0}, // R4 extra events ignored
        '{1'b0, 2'b01, 24'd3,       24'd3,       8'd4, 24'd3,       1'b0, 1'b1}, // R6 equal
        '{1'b1, 2'b01, 24'd2,       24'd5,       8'd4, 24'd0,       1'b0, 1'b1}, // R6 below
        '{1'b1, 2'b00, 24'd10,      24'd5,       8'd3, 24'd0,       1'b0, 1'b1}, // R2 none
        '{1'b0, 2'b11, 24'h012345,  24'h012340,  8'd2, 24'h012341,  1'b0, 1'b1}, // R2, R4
        '{1'b0, 2'b01, 24'h010001,  24'h00FFF0,  8'd2, 24'h00FFFF,  1'b0, 1'b1}  // R4 borrow into low part
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        evt_in = 1'b1;
        tick(4);
        evt_in = 1'b0;
        tick(4);
    endtask

    task automatic start(input logic up, input logic [1:0] e, input logic [W-1:0] ld, input logic [W-1:0] mt);
        dir_up = up; edge_sel = e; load_val = ld; match_val = mt;
        en_wr = 1'b1; en_wdata = 1'b1;
        tick(1);
        en_wr = 1'b0; en_wdata = 1'b0;
    endtask

    task automatic halt_wr();
        en_wr = 1'b1; en_wdata = 1'b0;
        tick(1);
        en_wr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        tick(3);
        // R1 reset state
        chk("R1 cnt", 32'(cnt_out), 32'h0);
        chk("R1 flag", 32'(match_flag), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 run_en", 32'(run_en), 32'h0);
        rst_n = 1'b1;
        tick(2);

        for (int i = 0; i < NV; i++) begin
            halt_wr();
            clear_flag();
            start(VECS[i].up, VECS[i].edg, VECS[i].ld, VECS[i].mt);
            for (int p = 0; p < int'(VECS[i].pulses); p++) pulse();
            chk($sformatf("vector %0d count (R2/R3/R4/R6)", i), 32'(cnt_out), 32'(VECS[i].ecnt));
            chk($sformatf("vector %0d flag (R3/R4/R6)", i), 32'(match_flag), 32'(VECS[i].eflag));
            chk($sformatf("vector %0d run_en (R4/R6)", i), 32'(run_en), 32'(VECS[i].een));
        end

        // R9 input latency: third rising edge
        halt_wr();
        clear_flag();
        start(1'b1, 2'b01, 24'd10, 24'd5);
        evt_in = 1'b1;
        tick(2);
        chk("R9 no change after two edges", 32'(cnt_out), 32'd0);
        tick(1);
        chk("R9 change at third edge", 32'(cnt_out), 32'd1);
        evt_in = 1'b0;
        tick(4);

        // R5 disable mid-run, then restart
        halt_wr();
        start(1'b0, 2'b01, 24'd8, 24'd3);
        pulse();
        chk("R5 running count", 32'(cnt_out), 32'd7);
        halt_wr();
        chk("R5 run_en after write 0", 32'(run_en), 32'd0);
        pulse();
        chk("R5 events ignored when disabled", 32'(cnt_out), 32'd7);
        start(1'b0, 2'b01, 24'd8, 24'd3);
        chk("R5 restart reloads", 32'(cnt_out), 32'd8);

        // R5 resume after automatic stop
        halt_wr();
        clear_flag();
        start(1'b0, 2'b01, 24'd5, 24'd3);
        pulse();
        pulse();
        chk("R4 auto stop run_en", 32'(run_en), 32'd0);
        pulse();
        chk("R5 stopped count held", 32'(cnt_out), 32'd5);
        start(1'b0, 2'b01, 24'd5, 24'd3);
        chk("R5 re-enabled", 32'(run_en), 32'd1);
        pulse();
        chk("R5 counting resumed", 32'(cnt_out), 32'd4);

        // R8 mask gating, R7 clear
        irq_mask = 1'b0;
        tick(1);
        chk("R8 flag present", 32'(match_flag), 32'd1);
        chk("R8 masked irq", 32'(irq), 32'd0);
        irq_mask = 1'b1;
        tick(1);
        chk("R8 unmasked irq", 32'(irq), 32'd1);
        clear_flag();
        chk("R7 flag cleared", 32'(match_flag), 32'd0);
        chk("R7 irq drops", 32'(irq), 32'd0);

        finish_run();
    end

endmodule